// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog peripheral on a simple register bus that completes each access in one cycle. A 24-bit down-counter is clocked by a fixed divide-by-4 prescaler. The prescaler advances only on clock cycles where an enable strobe is high. Software keeps the system alive by writing a two-value key to the feed register. A correct key pair reloads the counter from a programmable timeout constant.

The watchdog has two sticky control bits: one enables it and one selects reset on expiry. The counter starts only after the first correct key pair that follows setting the enable bit. From then on, two events pulse a one-cycle system reset when reset mode is set. The first is the counter expiring. The second is a key pair whose second value is wrong. Expiry also sets a status bit that software clears by writing 1 to it.

Four word registers sit at byte offsets 0x00 (mode), 0x04 (timeout constant), 0x08 (feed) and 0x0C (current count). Only address bits 3:2 select the register. Reads return data combinationally in the cycle of the access.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, mode reads 0, the timeout constant and the count both read 0xFF, and sys_rst_o is low.
- R2: While armed, the count drops by one on every fourth clock cycle that has tick_en high. It does not change in cycles without tick_en.
- R3: A feed has two parts. First, bits 7:0 = 0xAA are written to offset 0x08. Then bits 7:0 = 0x55 are written to offset 0x08 as the very next bus access (idle cycles may lie between the two). The clock edge of the second write loads the count from the timeout constant.
- R4: The count holds its value until a valid feed completes while mode bit 0 (enable) is already set. Setting enable alone does not start the count.
- R5: Mode bit 0 (enable) and mode bit 1 (reset mode) are sticky. Once either is 1, a write of 0 to it has no effect.
- R6: A write to offset 0x04 stores bits 23:0 of the write data. Any value below 0xFF is stored as 0xFF.
- R7: Expiry happens when a prescaler tick arrives while the watchdog is armed and the count is 0. On expiry the count reloads from the timeout constant and mode bit 2 sets. If reset mode is set, sys_rst_o is also high for the following cycle.
- R8: Mode bit 2 is cleared only by a mode write with bit 2 = 1. A mode write with bit 2 = 0 leaves it unchanged.
- R9: When armed with reset mode set, writing 0xAA and then any value other than 0x55 to the feed register raises sys_rst_o in the next cycle and does not reload the count. When not armed, the same sequence raises no pulse.
- R10: Any bus access to a register other than the feed register, read or write, placed between the two key writes cancels the sequence. So does a read of the feed register. A 0x55 written afterwards does nothing.
- R11: The count register at 0x0C is read-only and writes to it are ignored. The feed register reads as 0. bus_rdata is 0 in cycles without a read.
- R12: sys_rst_o is never high for two cycles in a row. A reset event in the cycle where the pulse is already high does not extend it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Prescaler enable strobe |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits 3:2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The key logic is tried with four patterns: a clean 0xAA/0x55 pair, a pair with a read between the two writes, a wrong second key before arming, and a wrong second key after arming. Together these separate the reload, abort and forced-reset paths, and show that the forced reset is gated by arming. The count is watched three ways: with tick_en held low, with tick_en running, and through a complete expiry from the minimum constant. This shows that the prescaler, the arming gate and the expiry reload act separately. Writes of zero to the sticky bits, writes to the read-only count, and timeout constants below the floor and above 24 bits show that those accesses are ignored or clamped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int BUS_AW = 4;

  typedef enum logic [1:0] {
    REG_MODE   = 2'd0,
    REG_TCONST = 2'd1,
    REG_FEED   = 2'd2,
    REG_COUNT  = 2'd3
  } reg_idx_e;

  typedef enum logic {
    FEED_IDLE = 1'b0,
    FEED_HALF = 1'b1
  } feed_st_e;

  localparam int MODE_EN_BIT = 0;
  localparam int MODE_RM_BIT = 1;
  localparam int MODE_TO_BIT = 2;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick = clk_en;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] ph_q, ph_d;

      always_comb begin
        ph_d = ph_q;
        if (clk_en) begin
          ph_d = (ph_q == LAST) ? '0 : ph_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
      end

      assign tick = clk_en && (ph_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
  import wdog_pkg::*;
#(
  parameter int              KEY_W = 8,
  parameter logic [KEY_W-1:0] KEY_A = KEY_FIRST,
  parameter logic [KEY_W-1:0] KEY_B = KEY_SECOND
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_acc,
  input  logic             feed_wr,
  input  logic [KEY_W-1:0] key,
  output logic             feed_ok,
  output logic             feed_bad
);
  feed_st_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    feed_ok  = 1'b0;
    feed_bad = 1'b0;
    if (feed_wr) begin
      if (state_q == FEED_HALF) begin
        if (key == KEY_B) feed_ok  = 1'b1;
        else              feed_bad = 1'b1;
        state_d = FEED_IDLE;
      end else if (key == KEY_A) begin
        state_d = FEED_HALF;
      end
    end else if (bus_acc) begin
      state_d = FEED_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FEED_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/wdog_downcnt.sv
module wdog_downcnt #(
  parameter int               CNT_W   = 24,
  parameter logic [CNT_W-1:0] RST_VAL = CNT_W'(255)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = run && tick && at_zero && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (run && tick) begin
      cnt_d = at_zero ? load_val : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int               CNT_W       = 24,
  parameter int               DATA_W      = 32,
  parameter int               PRE_DIV     = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] TC_FLOOR    = CNT_W'(255)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sys_rst_o
);
  localparam int KEY_W = 8;

  // reset: asserted at once, removed after SYNC_STAGES edges
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rsync_q[SYNC_STAGES-1];

  // decode
  reg_idx_e idx;
  logic     wr_mode, wr_tc, wr_feed;
  logic     unused_bits;

  assign idx     = reg_idx_e'(bus_addr[3:2]);
  assign wr_mode = bus_sel && bus_wr && (idx == REG_MODE);
  assign wr_tc   = bus_sel && bus_wr && (idx == REG_TCONST);
  assign wr_feed = bus_sel && bus_wr && (idx == REG_FEED);
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CNT_W]};

  // sub-blocks
  logic             tick_w, feed_ok_w, feed_bad_w, expire_w;
  logic [CNT_W-1:0] cnt_w;
  logic             en_q, rm_q, flag_q, armed_q, rst_q;
  logic             en_d, rm_d, flag_d, armed_d, rst_d;
  logic [CNT_W-1:0] tc_q, tc_d, wd_cnt;

  wdog_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .clk_en (tick_en),
    .tick   (tick_w)
  );

  wdog_feed_seq #(.KEY_W(KEY_W)) u_feed (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bus_acc  (bus_sel),
    .feed_wr  (wr_feed),
    .key      (bus_wdata[KEY_W-1:0]),
    .feed_ok  (feed_ok_w),
    .feed_bad (feed_bad_w)
  );

  wdog_downcnt #(.CNT_W(CNT_W), .RST_VAL(TC_FLOOR)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (armed_q),
    .tick     (tick_w),
    .load     (feed_ok_w),
    .load_val (tc_q),
    .count    (cnt_w),
    .expire   (expire_w)
  );

  // control and status next state
  assign wd_cnt = bus_wdata[CNT_W-1:0];

  always_comb begin
    en_d    = en_q;
    rm_d    = rm_q;
    flag_d  = flag_q;
    tc_d    = tc_q;
    armed_d = armed_q;
    if (wr_mode) begin
      en_d = en_q | bus_wdata[MODE_EN_BIT];
      rm_d = rm_q | bus_wdata[MODE_RM_BIT];
      if (bus_wdata[MODE_TO_BIT]) flag_d = 1'b0;
    end
    if (expire_w) flag_d = 1'b1;
    if (wr_tc) tc_d = (wd_cnt < TC_FLOOR) ? TC_FLOOR : wd_cnt;
    if (feed_ok_w && en_q) armed_d = 1'b1;
    rst_d = !rst_q && rm_q &&
            (expire_w || (feed_bad_w && armed_q));
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      en_q    <= 1'b0;
      rm_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
      tc_q    <= TC_FLOOR;
    end else begin
      en_q    <= en_d;
      rm_q    <= rm_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
      rst_q   <= rst_d;
      tc_q    <= tc_d;
    end
  end

  assign sys_rst_o = rst_q;

  // read path
  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (idx)
        REG_MODE:   bus_rdata = DATA_W'({flag_q, rm_q, en_q});
        REG_TCONST: bus_rdata = DATA_W'(tc_q);
        REG_FEED:   bus_rdata = '0;
        REG_COUNT:  bus_rdata = DATA_W'(cnt_w);
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
  parameter int               CNT_W    = 24,
  parameter logic [CNT_W-1:0] TC_FLOOR = CNT_W'(255)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_rst_o,
  input logic             en_q,
  input logic             rm_q,
  input logic             flag_q,
  input logic             armed_q,
  input logic             tick,
  input logic             feed_ok,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc_q
);
  // R5
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);

  // R5
  rm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rm_q |=> rm_q);

  // R12
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_o |=> !sys_rst_o);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick && !feed_ok && cnt != '0) |=>
      (cnt == $past(cnt) - {{(CNT_W-1){1'b0}}, 1'b1}));

  // R4
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !feed_ok) |=> $stable(cnt));

  // R3
  feed_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt == $past(tc_q)));

  // R6
  tc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= TC_FLOOR);

  // R7
  expire_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick && cnt == '0 && !feed_ok && rm_q && !sys_rst_o) |=>
      (sys_rst_o && flag_q));
endmodule

bind wdog_keyed wdog_keyed_chk #(.CNT_W(CNT_W), .TC_FLOOR(TC_FLOOR)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .sys_rst_o (sys_rst_o),
  .en_q      (en_q),
  .rm_q      (rm_q),
  .flag_q    (flag_q),
  .armed_q   (armed_q),
  .tick      (tick_w),
  .feed_ok   (feed_ok_w),
  .cnt       (cnt_w),
  .tc_q      (tc_q)
);

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  logic        clk = 1'b0;
  logic        rst_n, tick_en, bus_sel, bus_wr, sys_rst_o;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #10 clk = ~clk;

  wdog_keyed u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o)
  );

  int checks = 0, fails = 0;
  bit mon_on = 1'b0, done = 1'b0;

  // behavioural reference state
  int m_pre, m_cnt, m_tc, m_en, m_rm, m_flag, m_armed, m_st, m_rst;

  always @(posedge clk or negedge rst_n) begin : ref_model
    int tk, fw, key, ok, bad, nrst, fset;
    if (!rst_n) begin
      m_pre = 0; m_cnt = 255; m_tc = 255; m_en = 0; m_rm = 0;
      m_flag = 0; m_armed = 0; m_st = 0; m_rst = 0;
    end else begin
      tk = (tick_en && m_pre == 3);
      if (tick_en) m_pre = (m_pre + 1) % 4;
      key = int'(bus_wdata[7:0]);
      fw  = bus_sel && bus_wr && bus_addr[3:2] == 2'd2;
      ok  = fw && m_st == 1 && key == 'h55;
      bad = fw && m_st == 1 && key != 'h55;
      nrst = 0; fset = 0;
      if (ok) m_cnt = m_tc;
      else if (m_armed && tk) begin
        if (m_cnt == 0) begin
          m_cnt = m_tc; fset = 1;
          if (m_rm) nrst = 1;
        end else m_cnt = m_cnt - 1;
      end
      if (bad && m_armed && m_rm) nrst = 1;
      if (m_rst) nrst = 0;
      if (ok && m_en) m_armed = 1;
      if (fw) m_st = (m_st == 0 && key == 'hAA) ? 1 : 0;
      else if (bus_sel) m_st = 0;
      if (bus_sel && bus_wr && bus_addr[3:2] == 2'd0) begin
        if (bus_wdata[0]) m_en = 1;
        if (bus_wdata[1]) m_rm = 1;
        if (bus_wdata[2]) m_flag = 0;
      end
      if (fset) m_flag = 1;
      if (bus_sel && bus_wr && bus_addr[3:2] == 2'd1) begin
        m_tc = int'(bus_wdata[23:0]);
        if (m_tc < 255) m_tc = 255;
      end
      m_rst = nrst;
    end
  end

  function automatic logic [31:0] model_rd();
    if (!(bus_sel && !bus_wr)) return 32'd0;
    case (bus_addr[3:2])
      2'd0:    return 32'(m_en + 2 * m_rm + 4 * m_flag);
      2'd1:    return 32'(m_tc);
      2'd3:    return 32'(m_cnt);
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (mon_on) begin
      check("R12/R9 cycle sys_rst_o", {31'd0, sys_rst_o}, {31'd0, m_rst[0]});
      check("R11 cycle bus_rdata", bus_rdata, model_rd());
    end
  end

  task automatic drive(input logic s, input logic w, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    #1;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 4'h0, 32'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    drive(1'b1, 1'b1, a, d);
  endtask

  // read; compare with exp, or with the reference when use_ref is set
  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input bit use_ref,
                        input string tag, output logic [31:0] got);
    drive(1'b1, 1'b0, a, 32'd0);
    @(negedge clk);
    got = bus_rdata;
    check(tag, bus_rdata, use_ref ? model_rd() : exp);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'd0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
    end
  end

  initial begin : stim
    logic [31:0] v, c1, c2;
    int pulses;
    rst_n = 1'b0; tick_en = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'd0;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1 reset state
    check("R1 sys_rst_o after reset", {31'd0, sys_rst_o}, 32'd0);
    rd_chk(4'h0, 32'h0,  1'b0, "R1 mode reset", v);
    rd_chk(4'h4, 32'hFF, 1'b0, "R1 tconst reset", v);
    rd_chk(4'hC, 32'hFF, 1'b0, "R1 count reset", v);
    rd_chk(4'h8, 32'h0,  1'b0, "R11 feed reads zero", v);

    tick_en = 1'b1;
    idle(40);
    rd_chk(4'hC, 32'hFF, 1'b0, "R4 count idle before enable", v);

    // reset mode set, not yet armed: bad key must not pulse
    wr(4'h0, 32'h2);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h12);
    @(negedge clk);
    check("R9 no pulse when unarmed", {31'd0, sys_rst_o}, 32'd0);
    idle(2);

    wr(4'h0, 32'h1);
    idle(30);
    rd_chk(4'h0, 32'h3,  1'b0, "R5 mode after enable", v);
    rd_chk(4'hC, 32'hFF, 1'b0, "R4 enable alone does not arm", v);

    // R6 clamp and width
    wr(4'h4, 32'h10);
    rd_chk(4'h4, 32'hFF, 1'b0, "R6 floor clamp", v);
    wr(4'h4, 32'h01FF_FFFF);
    rd_chk(4'h4, 32'hFF_FFFF, 1'b0, "R6 upper bits dropped", v);
    wr(4'h4, 32'h1234);
    rd_chk(4'h4, 32'h1234, 1'b0, "R6 plain value", v);

    // R3 valid feed arms and reloads
    wr(4'h8, 32'hAA);
    idle(1);
    wr(4'h8, 32'h55);
    rd_chk(4'hC, 32'h0, 1'b1, "R3 count after feed", c1);
    idle(80);
    rd_chk(4'hC, 32'h0, 1'b1, "R2 count while running", c2);
    check("R2 count dropped by 20 or 21",
          32'((c1 - c2 == 32'd20) || (c1 - c2 == 32'd21)), 32'd1);

    // R2 no decrement without tick_en
    tick_en = 1'b0;
    rd_chk(4'hC, 32'h0, 1'b1, "R2 count at gate", c1);
    idle(50);
    rd_chk(4'hC, c1, 1'b0, "R2 count frozen without tick_en", v);
    tick_en = 1'b1;

    // R10 abort by intervening read
    idle(20);
    wr(4'h8, 32'hAA);
    rd_chk(4'h0, 32'h3, 1'b0, "R10 read between keys", v);
    wr(4'h8, 32'h55);
    rd_chk(4'hC, 32'h0, 1'b1, "R10 no reload after abort", c1);
    check("R10 count below constant", 32'(c1 < 32'h1234), 32'd1);

    // R11 count write ignored
    wr(4'hC, 32'h5);
    rd_chk(4'hC, 32'h0, 1'b1, "R11 count write ignored", v);
    check("R11 count not five", 32'(v != 32'h5), 32'd1);

    // R5 sticky bits
    wr(4'h0, 32'h0);
    rd_chk(4'h0, 32'h3, 1'b0, "R5 zero write ignored", v);

    // R9 malformed feed when armed
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h54);
    @(negedge clk);
    check("R9 pulse after bad key", {31'd0, sys_rst_o}, 32'd1);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'd0;
    @(negedge clk);
    check("R12 pulse one cycle", {31'd0, sys_rst_o}, 32'd0);

    // R7 expiry from minimum constant
    wr(4'h4, 32'h0);
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
    idle(1);
    pulses = 0;
    for (int i = 0; i < 1300; i++) begin
      @(negedge clk);
      if (sys_rst_o) pulses++;
    end
    check("R7 one expiry pulse", 32'(pulses), 32'd1);
    rd_chk(4'h0, 32'h7, 1'b0, "R7 timeout flag set", v);

    // R8 clear on write-one only
    wr(4'h0, 32'h3);
    rd_chk(4'h0, 32'h7, 1'b0, "R8 flag kept on zero write", v);
    wr(4'h0, 32'h4);
    rd_chk(4'h0, 32'h3, 1'b0, "R8 flag cleared by one", v);

    idle(4);
    done = 1'b1;
    mon_on = 1'b0;
    summary();
  end
endmodule